// File: doc/BRIEF.md
# Serial Configuration Port for a Knock-Sensing Front End

This block is a serial slave that sits between a host controller and the analog conditioning path of an engine knock detector. The host sends single-byte commands. Each byte names one target setting and carries its new value. The settings are the sensor channel, the amplifier gain, the bandpass centre code, the integrator time constant and the clock prescaler word. The block keeps these settings in registers and presents them as plain outputs to the analog path.

The serial clock, chip select and data input arrive without any timing relation to the system clock. The block samples them through two-flop synchronisers and detects their edges in the system clock domain. A byte takes effect only when chip select rises after exactly eight falling serial-clock edges, so a channel change is in place a few system cycles after the frame ends. While a frame is in progress, the data output returns the last accepted byte so the host can confirm what it sent.

The driver enable of the data output has a fixed priority. The diagnostic input wins over everything else. Next comes a disable bit in the prescaler word, and chip select is considered last.

Top module: `knock_spi_cfg`

## Requirements
- R1: A frame is captured only while `spi_cs_n` is low, one bit per falling edge of `spi_sck`, most-significant bit first.
- R2: Command decode on the received byte `b`. If `b[7:6]=00`, `bpf_code` takes `b[5:0]`. If `b[7:6]=01`, `int_tc_code` takes `b[5:0]`. If `b[7:6]=10`, `presc_code` takes `b[5:0]`. If `b[7:5]=110`, `gain_code` takes `b[4:0]`. If `b[7:5]=111`, `chan_sel` takes `b[0]` and bits 4..1 are ignored. A command changes only its own target.
- R3: A frame that ends with fewer or more than 8 falling clock edges is discarded. No setting changes and the readback byte does not change.
- R4: An accepted byte does not change any output before `spi_cs_n` rises. It is visible on the outputs no later than the third rising `clk` edge after `spi_cs_n` rises.
- R5: While `test_n` is high and `spi_cs_n` is high, `miso_oe` is 0. While `test_n` is high, `spi_cs_n` is low and `presc_code[0]` is 0, `miso_oe` is 1.
- R6: While `test_n` is high and `presc_code[0]` is 1, `miso_oe` is 0 even with `spi_cs_n` low.
- R7: While `test_n` is low, `miso_oe` is 1 whatever the state of `spi_cs_n` and `presc_code[0]`.
- R8: During a frame, `spi_miso` presents the last accepted byte, most-significant bit first. The first bit is valid within three `clk` cycles of `spi_cs_n` falling, and each rising `spi_sck` edge advances it by one bit.
- R9: After reset every setting is zero and the readback byte is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_cs_n | input | 1 | Chip select, active low, idles high |
| spi_mosi | input | 1 | Serial data from host |
| test_n | input | 1 | Diagnostic mode when low |
| spi_miso | output | 1 | Serial data to host |
| miso_oe | output | 1 | Driver enable for `spi_miso` |
| chan_sel | output | 1 | Sensor channel select |
| gain_code | output | 5 | Gain step code |
| bpf_code | output | 6 | Bandpass centre code |
| int_tc_code | output | 6 | Integrator time-constant code |
| presc_code | output | 6 | Prescaler word; bit 0 disables the data driver |

## Verification
The decode is driven with a sequence of bytes that reaches every command field. Each byte's value bits differ from the previous contents of its target, so a write that lands in the wrong register, or a field that is shifted by one bit, shows up as a mismatch in the untouched settings. Each frame also reads back the byte before it, which separates a correct most-significant-first shift order from a reversed one. Frames of seven and nine edges check the length rule. The enable priority is tried across the combinations of diagnostic pin, prescaler bit and chip select that tell the three levels apart.

// File: rtl/knock_spi_cfg.sv
module knock_spi_cfg #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sck,
  input  logic       spi_cs_n,
  input  logic       spi_mosi,
  input  logic       test_n,
  output logic       spi_miso,
  output logic       miso_oe,
  output logic       chan_sel,
  output logic [4:0] gain_code,
  output logic [5:0] bpf_code,
  output logic [5:0] int_tc_code,
  output logic [5:0] presc_code
);

  localparam int FRAME_BITS = 8;
  localparam int CNT_W      = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_BITS + 1);

  logic [SYNC_STAGES-1:0] sck_q, cs_q, mosi_q;
  logic sck_d, cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
      sck_d  <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sck_q  <= {sck_q[SYNC_STAGES-2:0], spi_sck};
      cs_q   <= {cs_q[SYNC_STAGES-2:0], spi_cs_n};
      mosi_q <= {mosi_q[SYNC_STAGES-2:0], spi_mosi};
      sck_d  <= sck_q[SYNC_STAGES-1];
      cs_d   <= cs_q[SYNC_STAGES-1];
    end
  end

  wire sck_s    = sck_q[SYNC_STAGES-1];
  wire cs_s     = cs_q[SYNC_STAGES-1];
  wire mosi_s   = mosi_q[SYNC_STAGES-1];
  wire sck_fall = sck_d & ~sck_s;
  wire sck_rise = ~sck_d & sck_s;
  wire cs_fall  = cs_d & ~cs_s;
  wire cs_rise  = ~cs_d & cs_s;
  wire active   = ~cs_s;

  logic [FRAME_BITS-1:0] rx_sr, rx_last, tx_sr;
  logic [CNT_W-1:0]      bit_cnt;

  wire frame_ok = cs_rise & (bit_cnt == CNT_FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sr   <= '0;
      bit_cnt <= '0;
    end else if (cs_fall) begin
      bit_cnt <= '0;
    end else if (active && sck_fall) begin
      rx_sr <= {rx_sr[FRAME_BITS-2:0], mosi_s};
      if (bit_cnt != CNT_OVER) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 tx_sr <= '0;
    else if (cs_fall)           tx_sr <= rx_last;
    else if (active && sck_rise) tx_sr <= {tx_sr[FRAME_BITS-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_last     <= '0;
      chan_sel    <= 1'b0;
      gain_code   <= '0;
      bpf_code    <= '0;
      int_tc_code <= '0;
      presc_code  <= '0;
    end else if (frame_ok) begin
      rx_last <= rx_sr;
      casez (rx_sr[7:5])
        3'b00?:  bpf_code    <= rx_sr[5:0];
        3'b01?:  int_tc_code <= rx_sr[5:0];
        3'b10?:  presc_code  <= rx_sr[5:0];
        3'b110:  gain_code   <= rx_sr[4:0];
        default: chan_sel    <= rx_sr[0];
      endcase
    end
  end

  assign spi_miso = tx_sr[FRAME_BITS-1];
  assign miso_oe  = ~test_n | (~presc_code[0] & ~spi_cs_n);

endmodule

// File: rtl/knock_spi_cfg_chk.sv
module knock_spi_cfg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       spi_cs_n,
  input logic       test_n,
  input logic       miso_oe,
  input logic       chan_sel,
  input logic [4:0] gain_code,
  input logic [5:0] bpf_code,
  input logic [5:0] int_tc_code,
  input logic [5:0] presc_code,
  input logic [3:0] bit_cnt
);

  wire [23:0] cfg = {chan_sel, gain_code, bpf_code, int_tc_code, presc_code};

  AST_DIAG_DRIVES: assert property (@(posedge clk) disable iff (!rst_n) !test_n |-> miso_oe); // R7
  AST_CS_HIGH_HIZ: assert property (@(posedge clk) disable iff (!rst_n) (test_n && spi_cs_n) |-> !miso_oe); // R5
  AST_PRESC_HIZ: assert property (@(posedge clk) disable iff (!rst_n) (test_n && presc_code[0]) |-> !miso_oe); // R6
  AST_CS_LOW_DRIVES: assert property (@(posedge clk) disable iff (!rst_n) (test_n && !spi_cs_n && !presc_code[0]) |-> miso_oe); // R5
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n, 1) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3) && $past(spi_cs_n, 4)) |-> $stable(cfg)); // R4
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) bit_cnt <= 4'd9); // R3

endmodule

bind knock_spi_cfg knock_spi_cfg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .test_n(test_n), .miso_oe(miso_oe),
  .chan_sel(chan_sel), .gain_code(gain_code), .bpf_code(bpf_code),
  .int_tc_code(int_tc_code), .presc_code(presc_code), .bit_cnt(bit_cnt)
);

// File: tb/knock_spi_cfg_tb.sv
module knock_spi_cfg_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, test_n = 1'b1;
  logic miso, oe, chan;
  logic [4:0] gain;
  logic [5:0] bpf, itc, presc;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  knock_spi_cfg u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .test_n(test_n), .spi_miso(miso), .miso_oe(oe), .chan_sel(chan),
    .gain_code(gain), .bpf_code(bpf), .int_tc_code(itc), .presc_code(presc)
  );

  // {byte, chan, gain, bpf, int_tc, presc} after the byte is accepted
  localparam logic [31:0] VEC [0:8] = '{
    {8'h2A, 1'b0, 5'h00, 6'h2A, 6'h00, 6'h00},
    {8'h55, 1'b0, 5'h00, 6'h2A, 6'h15, 6'h00},
    {8'hD3, 1'b0, 5'h13, 6'h2A, 6'h15, 6'h00},
    {8'hE1, 1'b1, 5'h13, 6'h2A, 6'h15, 6'h00},
    {8'h8C, 1'b1, 5'h13, 6'h2A, 6'h15, 6'h0C},
    {8'h3F, 1'b1, 5'h13, 6'h3F, 6'h15, 6'h0C},
    {8'hDF, 1'b1, 5'h1F, 6'h3F, 6'h15, 6'h0C},
    {8'hE0, 1'b0, 5'h1F, 6'h3F, 6'h15, 6'h0C},
    {8'h40, 1'b0, 5'h1F, 6'h3F, 6'h00, 6'h0C}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] cfg();
    return {chan, gain, bpf, itc, presc};
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic open_frame();
    @(negedge clk) cs_n = 1'b0;
    wait_clk(8);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n, output logic [7:0] rd);
    rd = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk) mosi = (i < 8) ? b[7-i] : 1'b0;
      wait_clk(4);
      if (i < 8) rd[7-i] = miso;
      sck = 1'b1;
      wait_clk(4);
      sck = 1'b0;
    end
    wait_clk(4);
  endtask

  task automatic close_frame();
    @(negedge clk) cs_n = 1'b1;
    wait_clk(8);
  endtask

  task automatic xfer(input logic [7:0] b, input int n, output logic [7:0] rd);
    open_frame();
    send_bits(b, n, rd);
    close_frame();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd, prev;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(4);
    // R9 reset state
    chk("R9 settings", {8'h0, cfg()}, 32'h0);
    chk("R5 idle enable", oe, 1'b0);

    // R1/R2 decode table with R8 readback
    prev = 8'h00;
    for (int k = 0; k < 9; k++) begin
      xfer(VEC[k][31:24], 8, rd);
      chk("R1/R2 settings", {8'h0, cfg()}, {8'h0, VEC[k][23:0]});
      chk(k == 0 ? "R9 readback" : "R8 readback", rd, prev);
      prev = VEC[k][31:24];
    end

    // R3 short and long frames discarded
    xfer(8'hC5, 7, rd);
    chk("R3 short frame", {8'h0, cfg()}, {8'h0, VEC[8][23:0]});
    xfer(8'hE7, 9, rd);
    chk("R3 long frame", {8'h0, cfg()}, {8'h0, VEC[8][23:0]});
    xfer(8'h00, 8, rd);
    chk("R3 readback unchanged", rd, 8'h40);
    xfer(8'h3F, 8, rd);

    // R4 commit timing
    open_frame();
    send_bits(8'hE1, 8, rd);
    chk("R4 before rise", chan, 1'b0);
    @(negedge clk) cs_n = 1'b1;
    wait_clk(3);
    chk("R4 after rise", chan, 1'b1);
    wait_clk(5);

    // R2 reserved bits in channel command ignored
    xfer(8'hFE, 8, rd);
    chk("R2 reserved bits", {8'h0, cfg()}, {8'h0, 1'b0, 5'h1F, 6'h3F, 6'h00, 6'h0C});

    // R5 enable follows chip select
    open_frame();
    chk("R5 cs low drives", oe, 1'b1);
    send_bits(8'h81, 8, rd);
    close_frame();
    chk("R5 cs high hiz", oe, 1'b0);

    // R6 prescaler bit forces high impedance
    open_frame();
    chk("R6 presc hiz", oe, 1'b0);
    send_bits(8'h00, 8, rd);
    chk("R8 readback while hiz", rd, 8'h81);
    close_frame();

    // R7 diagnostic mode overrides
    @(negedge clk) test_n = 1'b0;
    wait_clk(1);
    chk("R7 diag cs high", oe, 1'b1);
    @(negedge clk) cs_n = 1'b0;
    wait_clk(1);
    chk("R7 diag presc set", oe, 1'b1);
    @(negedge clk) cs_n = 1'b1;
    test_n = 1'b1;
    wait_clk(8);
    chk("R6 back to hiz", oe, 1'b0);

    xfer(8'h80, 8, rd);
    chk("R2 presc clear", presc, 6'h00);
    open_frame();
    chk("R5 driven again", oe, 1'b1);
    send_bits(8'h00, 8, rd);
    close_frame();
    chk("R8 readback", rd, 8'h80);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule